// File: doc/BRIEF.md
# Link Port Byte-Serial Transmitter

This block is the sending half of a point-to-point link. A host writes 32-bit words into a two-word transmit buffer. The block sends each word over an 8-bit data bus as four bytes, with the least significant byte first. A strobe clock is produced alongside the data by dividing the system clock by two. The receiver throttles the link with an acknowledge line. The transmitter begins a new word only when acknowledge is high at the boundary between words.

Start-up uses a handshake. After the transmitter is enabled, its clock line stays low and it moves no data. It waits for the receiver to show it is ready, which the receiver does by driving acknowledge from low to high. On that first rising edge the block raises its service request, and from then on it may drain the buffer. Disabling the transmitter clears the service request and stops new words from starting. The clock line then returns low and stays there.

Top module: `lp_tx_top`

## Requirements
- R1: After reset, and whenever the transmitter is idle and disabled, `lclk_out` is 0. Out of reset, `ldata_out` is 0, `srv_req` is 0, `buf_empty` is 1 and `buf_full` is 0.
- R2: While enabled with `ack_in` low and no word in flight, no rising edge appears on `lclk_out` and the buffer keeps its contents.
- R3: `srv_req` goes to 1 one cycle after the first clock edge at which `ack_in` is 1, having been 0 at the edge before, while `enable` is 1. It then stays at 1 until `enable` drops.
- R4: Every rising edge of `lclk_out` comes in the same cycle that a new byte appears on `ldata_out`. No rising edge comes before the first byte. `lclk_out` is high for one system cycle and low for the next, so within a word the rising edges are exactly 2 cycles apart.
- R5: Each word goes out as 4 bytes in the order bits [7:0], [15:8], [23:16], [31:24]. `ldata_out` does not change while `lclk_out` falls.
- R6: The buffer holds two words. `buf_full` is 1 when it holds two and `buf_empty` is 1 when it holds none. A write made while `buf_full` is 1 is dropped and never transmitted.
- R7: `ack_in` is looked at only at word boundaries. A word that has started always sends all 4 bytes, even if `ack_in` falls partway through. The next word waits in the buffer until `ack_in` is 1 again.
- R8: While `ack_in` stays high and the buffer is not empty, words follow each other with no gap. The first rising edge of a word comes 2 cycles after the last rising edge of the word before it.
- R9: When `enable` is 0, `srv_req` is 0 from the next cycle and no new word starts. `lclk_out` ends low even if words remain buffered and `ack_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 32 | Host write word |
| buf_full | output | 1 | Transmit buffer holds two words |
| buf_empty | output | 1 | Transmit buffer holds no word |
| ack_in | input | 1 | Receiver acknowledge; high means a word may start |
| lclk_out | output | 1 | Link strobe clock, system clock divided by two |
| ldata_out | output | 8 | Link data byte |
| srv_req | output | 1 | Transmit service request |

## Verification
The assertions take for granted that `ack_in` is synchronous to `clk`. They also assume `ack_in` starts low after `enable` rises, so that the handshake edge can be seen, and that the host may keep writing while the buffer is full. To stay within this, the stimulus changes every input half a period away from the active edge. It lowers acknowledge before each enable, and it deliberately writes into a full buffer to show that the write is dropped. Acknowledge is dropped inside a word, never at the exact boundary cycle, so that the completion rule can be observed without ambiguity.

// File: rtl/lp_tx_pkg.sv
package lp_tx_pkg;

    // Serialiser state: waiting at a word boundary, or shifting bytes out
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } lp_tx_state_e;

    // Default geometry of the link
    localparam int unsigned LP_WORD_W  = 32;
    localparam int unsigned LP_LANE_W  = 8;
    localparam int unsigned LP_BUF_DEP = 2;

endpackage

// File: rtl/lp_tx_buf.sv
// Small circular word buffer between the host write port and the serialiser.
module lp_tx_buf #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         full,
    output logic         empty
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } buf_s;

    buf_s buf_d, buf_q;
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        buf_d   = buf_q;
        push_ok = push && (buf_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (buf_q.cnt != '0);

        if (push_ok) begin
            buf_d.mem[buf_q.wp] = push_data;
            buf_d.wp            = ptr_next(buf_q.wp);
        end
        if (pop_ok) begin
            buf_d.rp = ptr_next(buf_q.rp);
        end

        case ({push_ok, pop_ok})
            2'b10:   buf_d.cnt = buf_q.cnt + 1'b1;
            2'b01:   buf_d.cnt = buf_q.cnt - 1'b1;
            default: buf_d.cnt = buf_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign head_data = buf_q.mem[buf_q.rp];
    assign full      = (buf_q.cnt == CW'(DEPTH));
    assign empty     = (buf_q.cnt == '0);

endmodule

// File: rtl/lp_tx_hs.sv
// Enable handshake: watches acknowledge for its first rising edge after enable.
module lp_tx_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack_in,
    output logic ready
);

    typedef struct packed {
        logic ack_prev;
        logic ready;
    } hs_s;

    hs_s hs_d, hs_q;

    always_comb begin
        hs_d          = hs_q;
        hs_d.ack_prev = ack_in;
        if (!enable) begin
            hs_d.ready = 1'b0;
        end else if (ack_in && !hs_q.ack_prev) begin
            hs_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign ready = hs_q.ready;

endmodule

// File: rtl/lp_tx_ser.sv
// Byte serialiser with divide-by-two strobe clock; acknowledge checked per word.
module lp_tx_ser
    import lp_tx_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ready,
    input  logic              ack_in,
    input  logic              word_avail,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_take,
    output logic              busy,
    output logic              lclk,
    output logic [LANE_W-1:0] ldata
);

    localparam int unsigned BEATS = WORD_W / LANE_W;
    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    typedef struct packed {
        lp_tx_state_e      state;
        logic              high_ph;
        logic [CNT_W-1:0]  beat;
        logic [WORD_W-1:0] shreg;
        logic              lclk;
        logic [LANE_W-1:0] data;
    } ser_s;

    ser_s ser_d, ser_q;
    logic can_start;

    always_comb begin
        ser_d     = ser_q;
        word_take = 1'b0;
        can_start = enable && ready && ack_in && word_avail;

        unique case (ser_q.state)
            TX_IDLE: begin
                if (can_start) begin
                    word_take     = 1'b1;
                    ser_d.state   = TX_SEND;
                    ser_d.high_ph = 1'b1;
                    ser_d.beat    = '0;
                    ser_d.lclk    = 1'b1;
                    ser_d.data    = word_in[LANE_W-1:0];
                    ser_d.shreg   = word_in >> LANE_W;
                end
            end
            TX_SEND: begin
                if (ser_q.high_ph) begin
                    ser_d.high_ph = 1'b0;
                    ser_d.lclk    = 1'b0;
                end else if (ser_q.beat != LAST_BEAT) begin
                    ser_d.high_ph = 1'b1;
                    ser_d.lclk    = 1'b1;
                    ser_d.beat    = ser_q.beat + 1'b1;
                    ser_d.data    = ser_q.shreg[LANE_W-1:0];
                    ser_d.shreg   = ser_q.shreg >> LANE_W;
                end else if (can_start) begin
                    word_take     = 1'b1;
                    ser_d.high_ph = 1'b1;
                    ser_d.beat    = '0;
                    ser_d.lclk    = 1'b1;
                    ser_d.data    = word_in[LANE_W-1:0];
                    ser_d.shreg   = word_in >> LANE_W;
                end else begin
                    ser_d.state = TX_IDLE;
                end
            end
            default: ser_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q       <= '0;
            ser_q.state <= TX_IDLE;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign busy  = (ser_q.state == TX_SEND);
    assign lclk  = ser_q.lclk;
    assign ldata = ser_q.data;

endmodule

// File: rtl/lp_tx_top.sv
// Link port transmitter: buffer, enable handshake and byte serialiser.
module lp_tx_top
    import lp_tx_pkg::*;
#(
    parameter int unsigned WORD_W  = LP_WORD_W,
    parameter int unsigned LANE_W  = LP_LANE_W,
    parameter int unsigned BUF_DEP = LP_BUF_DEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              buf_full,
    output logic              buf_empty,
    input  logic              ack_in,
    output logic              lclk_out,
    output logic [LANE_W-1:0] ldata_out,
    output logic              srv_req
);

    logic [WORD_W-1:0] head_word;
    logic              take_word;
    logic              hs_ready;
    logic              tx_busy;

    lp_tx_buf #(
        .W     (WORD_W),
        .DEPTH (BUF_DEP)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (take_word),
        .head_data (head_word),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    lp_tx_hs u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .ack_in (ack_in),
        .ready  (hs_ready)
    );

    lp_tx_ser #(
        .WORD_W (WORD_W),
        .LANE_W (LANE_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .ready      (hs_ready),
        .ack_in     (ack_in),
        .word_avail (!buf_empty),
        .word_in    (head_word),
        .word_take  (take_word),
        .busy       (tx_busy),
        .lclk       (lclk_out),
        .ldata      (ldata_out)
    );

    assign srv_req = hs_ready;

endmodule

// File: rtl/lp_tx_chk.sv
// Temporal checks for the link transmitter, attached by bind.
module lp_tx_chk #(
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              ack_in,
    input logic              buf_full,
    input logic              buf_empty,
    input logic              lclk_out,
    input logic [LANE_W-1:0] ldata_out,
    input logic              srv_req,
    input logic              busy
);

    p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lclk_out);

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ack_in) |=> !lclk_out);

    p_srv_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srv_req) |-> ($past(ack_in) && $past(enable)));

    p_clk_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lclk_out |=> !lclk_out);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lclk_out) |-> $stable(ldata_out));

    p_buf_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full && buf_empty));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |=> !buf_empty);

    p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ack_in) && $past(srv_req)));

    p_srv_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !srv_req);

endmodule

bind lp_tx_top lp_tx_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .ack_in    (ack_in),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .lclk_out  (lclk_out),
    .ldata_out (ldata_out),
    .srv_req   (srv_req),
    .busy      (tx_busy)
);

// File: tb/lp_tx_top_tb_top.sv
`timescale 1ns/1ps
module lp_tx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ack_in = 1'b0;
    logic        buf_full, buf_empty, lclk_out, srv_req;
    logic [7:0]  ldata_out;

    lp_tx_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .buf_full  (buf_full),
        .buf_empty (buf_empty),
        .ack_in    (ack_in),
        .lclk_out  (lclk_out),
        .ldata_out (ldata_out),
        .srv_req   (srv_req)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Stimulus table: words streamed back to back (R5, R8)
    localparam logic [31:0] VEC [6] = '{
        32'h4433_2211, 32'hA5C3_0FF0, 32'h0000_00FF,
        32'hFF00_0000, 32'h1357_9BDF, 32'h8001_7E42
    };
    localparam logic [31:0] JUNK = 32'hDEAD_BEEF;
    localparam logic [31:0] W_A  = 32'h0BAD_F00D;
    localparam logic [31:0] W_B  = 32'h6655_7788;
    localparam logic [31:0] W_C  = 32'hC0FF_EE01;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: capture the byte present at every rising edge of the link clock
    logic       prev_lclk = 1'b0;
    logic [7:0] cap   [64];
    int         cap_t [64];
    int         rises = 0;

    always @(negedge clk) begin
        if (lclk_out && !prev_lclk) begin
            if (rises < 64) begin
                cap[rises]   <= ldata_out;
                cap_t[rises] <= cyc;
            end
            rises <= rises + 1;
        end
        prev_lclk <= lclk_out;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        for (int g = 0; g < 1000 && buf_full; g++) step();
        wr_valid = 1'b1;
        wr_data  = w;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic push_force(input logic [31:0] w);
        wr_valid = 1'b1;
        wr_data  = w;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        for (int g = 0; g < 2000 && rises < n; g++) step();
    endtask

    task automatic chk_word(input int base, input logic [31:0] w, input string req);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] e;
            e = w[8*b +: 8];
            chk(cap[base+b] == e, req, "byte order", cap[base+b], e);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", rises, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        // ---- R1: reset state
        step(); step(); step();
        chk(lclk_out == 1'b0,  "R1", "lclk in reset", lclk_out, 0);
        chk(ldata_out == 8'h0, "R1", "data in reset", ldata_out, 0);
        chk(srv_req == 1'b0,   "R1", "srv_req in reset", srv_req, 0);
        chk(buf_empty == 1'b1, "R1", "empty in reset", buf_empty, 1);
        chk(buf_full == 1'b0,  "R1", "full in reset", buf_full, 0);
        rst_n = 1'b1;
        step();

        // ---- R2/R6: enabled, acknowledge low, buffer filled
        enable = 1'b1;
        step();
        push(VEC[0]);
        push(VEC[1]);
        chk(buf_full == 1'b1,  "R6", "full after two", buf_full, 1);
        chk(buf_empty == 1'b0, "R6", "not empty", buf_empty, 0);
        push_force(JUNK);      // dropped: buffer full (R6)
        repeat (10) step();
        chk(rises == 0,       "R2", "no clock while ack low", rises, 0);
        chk(srv_req == 1'b0,  "R3", "no request before ack", srv_req, 0);
        chk(buf_full == 1'b1, "R2", "buffer held", buf_full, 1);

        // ---- R3/R4: handshake edge, then first byte with first clock edge
        ack_in = 1'b1;
        step();
        chk(srv_req == 1'b1, "R3", "request after ack rise", srv_req, 1);
        chk(rises == 0,      "R4", "no edge before data", rises, 0);
        step();
        chk(rises == 1,      "R4", "first edge with first byte", rises, 1);
        chk(lclk_out == 1'b1, "R4", "clock high", lclk_out, 1);
        step();
        chk(lclk_out == 1'b0, "R4", "clock low next cycle", lclk_out, 0);

        // ---- table walk: stream remaining words (R5, R8)
        for (int k = 2; k < 6; k++) push(VEC[k]);
        wait_rises(24);
        repeat (12) step();
        chk(rises == 24, "R6", "overflow word dropped", rises, 24);
        for (int k = 0; k < 6; k++) chk_word(4*k, VEC[k], "R5");
        for (int i = 1; i < 24; i++)
            chk(cap_t[i] - cap_t[i-1] == 2, (i % 4 == 0) ? "R8" : "R4",
                "edge spacing", cap_t[i] - cap_t[i-1], 2);
        chk(buf_empty == 1'b1, "R6", "empty after drain", buf_empty, 1);
        chk(srv_req == 1'b1,   "R3", "request held", srv_req, 1);

        // ---- R7: acknowledge drops inside a word
        base = rises;
        push(W_A);
        wait_rises(base + 1);
        ack_in = 1'b0;
        push(W_B);
        repeat (20) step();
        chk(rises == base + 4, "R7", "started word completes", rises, base + 4);
        chk(buf_empty == 1'b0, "R7", "next word held", buf_empty, 0);
        chk(lclk_out == 1'b0,  "R7", "clock idle low", lclk_out, 0);
        chk_word(base, W_A, "R7");
        ack_in = 1'b1;
        repeat (20) step();
        chk(rises == base + 8, "R7", "held word sent on ack", rises, base + 8);
        chk_word(base + 4, W_B, "R7");

        // ---- R9: disable
        enable = 1'b0;
        step();
        chk(srv_req == 1'b0, "R9", "request cleared", srv_req, 0);
        push(W_C);
        repeat (20) step();
        chk(rises == base + 8,  "R9", "no word while disabled", rises, base + 8);
        chk(lclk_out == 1'b0,   "R9", "clock low when disabled", lclk_out, 0);
        chk(buf_empty == 1'b0,  "R9", "word stays buffered", buf_empty, 0);

        // ---- R3: re-enable needs a fresh acknowledge edge
        ack_in = 1'b0;
        enable = 1'b1;
        step(); step();
        chk(srv_req == 1'b0, "R3", "no request without edge", srv_req, 0);
        ack_in = 1'b1;
        repeat (20) step();
        chk(srv_req == 1'b1,     "R3", "request after new edge", srv_req, 1);
        chk(rises == base + 12,  "R3", "word sent after handshake", rises, base + 12);
        chk_word(base + 8, W_C, "R5");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule